// File: doc/BRIEF.md
# Register-Mapped Serial Port with Single-Character Buffering

This block is an asynchronous serial transmitter and receiver that a processor reaches through a narrow address/data register port. Two adjacent addresses make up the whole programming model. The base address carries characters: a write queues one for sending, and a read takes the last one received. The next address is shared. Writing it sets the baud divisor, and reading it returns a status byte.

Each direction has a single holding stage. On the transmit side, one waiting character sits in front of the shift register, so software can queue the next byte while the current one is still leaving the pin. On the receive side, one finished character is kept behind the shift register while the next one arrives. A programmable divisor paces every bit and uses sixteen ticks per bit. Frames have eight data bits, no parity and one stop bit. The pins use plain logic levels, and the line idles high.

Top module: `regport_uart`

## Requirements
- R1: A write to address BASE+1 loads the baud divisor `d` from the write data. Each serial bit then lasts 16 ticks, where one tick occurs every `d+1` clock cycles. With `d=0`, a bit is exactly 16 cycles.
- R2: A read of BASE+1 returns the status byte. Bit 0 is receive-ready, bit 1 is transmit-full and bit 2 is overrun. All other bits read 0.
- R3: A transmitted frame has one low start bit, then 8 data bits least-significant first, then one high stop bit. Between frames the `txd` pin stays high.
- R4: A write to BASE is accepted while the transmit holding stage is empty. That character starts shifting, and a second write fills the holding stage and sets transmit-full. A write made while transmit-full is set is discarded, so it never appears on `txd`.
- R5: A received frame with a high stop bit sets receive-ready. A read of BASE returns the data byte, and that read clears receive-ready.
- R6: If a frame completes while receive-ready is already set, the new byte replaces the held byte and the overrun bit is set. The next read of BASE clears both flags.
- R7: The receive line is resynchronised before use. A low pulse shorter than half a bit is not taken as a start bit. A frame whose stop bit is low is dropped and leaves receive-ready clear.
- R8: After reset, `txd` is high, the divisor is 0 and the status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a read of BASE consumes the received byte |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_rd` |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous to `clk` |

## Verification
The hardest state to reach is a write made while transmit-full is set. That state lasts only while an earlier character is still on the wire and the holding stage is loaded behind it. The bench runs a serial monitor in parallel and issues three back-to-back writes, so the third write lands in that window. The monitor then checks that exactly two frames leave the pin. Overrun is reached by sending two frames with no read between them. The start-bit filter is exercised with a short low glitch on `rxd`, followed by a frame whose stop bit is forced low.

// File: rtl/uart_pkg.sv
package uart_pkg;
   typedef enum logic [1:0] {
      LN_IDLE  = 2'd0,
      LN_START = 2'd1,
      LN_DATA  = 2'd2,
      LN_STOP  = 2'd3
   } line_state_e;

   localparam int ST_READY   = 0;
   localparam int ST_TXFULL  = 1;
   localparam int ST_OVERRUN = 2;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_load,
   input  logic [DIV_W-1:0] div_value,
   output logic             tick,
   output logic [DIV_W-1:0] div_q
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (div_load) begin
         div_q <= div_value;
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
   import uart_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   output logic              busy,
   output logic              txd
);
   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
   localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_W - 1);

   line_state_e       st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] hold_q;
   logic              hold_v;
   logic              take;
   logic              bit_end;

   assign take    = (st_q == LN_IDLE) && hold_v;
   assign bit_end = tick && (cnt_q == LAST_TICK);
   assign full    = hold_v;
   assign busy    = (st_q != LN_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         hold_v <= 1'b0;
      end else begin
         if (wr_en && !hold_v) begin
            hold_q <= wr_data;
            hold_v <= 1'b1;
         end else if (take) begin
            hold_v <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LN_IDLE;
         cnt_q <= '0;
         idx_q <= '0;
         sh_q  <= '0;
         txd   <= 1'b1;
      end else begin
         if (st_q != LN_IDLE && tick) cnt_q <= cnt_q + 1'b1;
         case (st_q)
            LN_IDLE: begin
               if (take) begin
                  sh_q  <= hold_q;
                  st_q  <= LN_START;
                  cnt_q <= '0;
                  txd   <= 1'b0;
               end
            end
            LN_START: begin
               if (bit_end) begin
                  st_q  <= LN_DATA;
                  idx_q <= '0;
                  txd   <= sh_q[0];
               end
            end
            LN_DATA: begin
               if (bit_end) begin
                  if (idx_q == LAST_BIT) begin
                     st_q <= LN_STOP;
                     txd  <= 1'b1;
                  end else begin
                     sh_q  <= sh_q >> 1;
                     txd   <= sh_q[1];
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: begin
               if (bit_end) st_q <= LN_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
   import uart_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   output logic              done,
   output logic [DATA_W-1:0] data
);
   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
   localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OSR / 2 - 1);
   localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_W - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   rx_prev;
   line_state_e            st_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [IDX_W-1:0]       idx_q;
   logic [DATA_W-1:0]      sh_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= rxd;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
         end
      end
   endgenerate

   assign rx_s = sync_q[SYNC_STAGES-1];
   assign data = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_prev <= 1'b1;
         st_q    <= LN_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         done    <= 1'b0;
      end else begin
         rx_prev <= rx_s;
         done    <= 1'b0;
         case (st_q)
            LN_IDLE: begin
               if (rx_prev && !rx_s) begin
                  st_q  <= LN_START;
                  cnt_q <= '0;
               end
            end
            LN_START: begin
               if (tick) begin
                  if (cnt_q == MID_TICK) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     st_q  <= rx_s ? LN_IDLE : LN_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            LN_DATA: begin
               if (tick) begin
                  if (cnt_q == LAST_TICK) begin
                     cnt_q <= '0;
                     sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                     if (idx_q == LAST_BIT) st_q <= LN_STOP;
                     else                   idx_q <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               if (tick) begin
                  if (cnt_q == LAST_TICK) begin
                     cnt_q <= '0;
                     done  <= rx_s;
                     st_q  <= LN_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/regport_uart.sv
module regport_uart
   import uart_pkg::*;
#(
   parameter int               ADDR_W      = 8,
   parameter int               DATA_W      = 8,
   parameter int               DIV_W       = 8,
   parameter int               OSR         = 16,
   parameter int               SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              txd,
   input  logic              rxd
);
   localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR + 1'b1;

   generate
      if (DATA_W < 3)                begin : g_bad_dw   $error("DATA_W must hold three status bits"); end
      if (DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_div $error("DIV_W must be 1..DATA_W"); end
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr $error("OSR must be a power of two >= 4"); end
      if (SYNC_STAGES < 1)           begin : g_bad_sync $error("SYNC_STAGES must be >= 1"); end
   endgenerate

   logic              wr_data, wr_ctrl, rd_data, rd_ctrl;
   logic              tick;
   logic [DIV_W-1:0]  div_q;
   logic              tx_full, tx_busy;
   logic              rx_done;
   logic [DATA_W-1:0] rx_word;
   logic [DATA_W-1:0] rx_hold;
   logic              rx_ready, rx_ovr;
   logic [DATA_W-1:0] status;

   assign wr_data = bus_wr && (bus_addr == DATA_ADDR);
   assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
   assign rd_data = bus_rd && (bus_addr == DATA_ADDR);
   assign rd_ctrl = bus_rd && (bus_addr == CTRL_ADDR);

   uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_load  (wr_ctrl),
      .div_value (bus_wdata[DIV_W-1:0]),
      .tick      (tick),
      .div_q     (div_q)
   );

   uart_tx_path #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_data),
      .wr_data (bus_wdata),
      .full    (tx_full),
      .busy    (tx_busy),
      .txd     (txd)
   );

   uart_rx_path #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .rxd   (rxd),
      .done  (rx_done),
      .data  (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_hold  <= '0;
         rx_ready <= 1'b0;
         rx_ovr   <= 1'b0;
      end else if (rx_done) begin
         rx_hold  <= rx_word;
         rx_ready <= 1'b1;
         rx_ovr   <= rx_ready && !rd_data;
      end else if (rd_data) begin
         rx_ready <= 1'b0;
         rx_ovr   <= 1'b0;
      end
   end

   always_comb begin
      status             = '0;
      status[ST_READY]   = rx_ready;
      status[ST_TXFULL]  = tx_full;
      status[ST_OVERRUN] = rx_ovr;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_data)      bus_rdata = rx_hold;
      else if (rd_ctrl) bus_rdata = status;
   end
endmodule

// File: rtl/regport_uart_chk.sv
module regport_uart_chk #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_ctrl,
   input logic              wr_data,
   input logic              rd_data,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DIV_W-1:0]  div_q,
   input logic              tx_busy,
   input logic              tx_full,
   input logic [DATA_W-1:0] hold_q,
   input logic              txd,
   input logic              rx_done,
   input logic              rx_ready,
   input logic              rx_ovr
);
   // R1: divisor write takes effect on the next cycle
   a_r1_div_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> div_q == $past(bus_wdata[DIV_W-1:0]));
   // R3: an idle transmitter holds the line at mark
   a_r3_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);
   // R3: a frame opens with a low start bit
   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> !txd);
   // R4: a write while full leaves the holding stage untouched
   a_r4_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && wr_data) |=> hold_q == $past(hold_q));
   // R5: a data read without a new arrival clears ready
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !rx_ready && !rx_ovr);
   // R6: arrival on a pending character flags overrun
   a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && rx_done && !rd_data) |=> rx_ovr && rx_ready);
endmodule

bind regport_uart regport_uart_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_ctrl   (wr_ctrl),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .bus_wdata (bus_wdata),
   .div_q     (div_q),
   .tx_busy   (tx_busy),
   .tx_full   (tx_full),
   .hold_q    (u_tx.hold_q),
   .txd       (txd),
   .rx_done   (rx_done),
   .rx_ready  (rx_ready),
   .rx_ovr    (rx_ovr)
);

// File: tb/tb_regport_uart.sv
module tb_regport_uart;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_DATA = 8'hC0;
   localparam logic [7:0] A_CTRL = 8'hC1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       txd;
   logic       rxd = 1'b1;

   int checks = 0;
   int errors = 0;
   int bp = 16;

   regport_uart dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .txd(txd), .rxd(rxd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] exp_status(input logic rdy, input logic full, input logic ovr);
      return {5'b0, ovr, full, rdy};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #(CLK_PERIOD/4);
      d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_div(input int d);
      bus_write(A_CTRL, 8'(d));
      bp = 16 * (d + 1);
   endtask

   task automatic drive_frame(input logic [7:0] b, input logic stop);
      logic [9:0] f;
      f = {stop, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         @(posedge clk); #1 rxd = f[i];
         repeat (bp - 1) @(posedge clk);
      end
      @(posedge clk); #1 rxd = 1'b1;
      repeat (2 * bp) @(posedge clk);
   endtask

   task automatic capture_tx(output logic [7:0] b, output bit ok);
      int guard;
      ok = 1'b1; guard = 0; b = '0;
      @(posedge clk); #1;
      while (txd !== 1'b0 && guard < 20 * bp) begin
         @(posedge clk); #1; guard++;
      end
      if (guard >= 20 * bp) begin ok = 1'b0; return; end
      repeat (bp / 2) @(posedge clk);
      #1;
      if (txd !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (bp) @(posedge clk);
         #1 b[i] = txd;
      end
      repeat (bp) @(posedge clk);
      #1;
      if (txd !== 1'b1) ok = 1'b0;
   endtask

   task automatic send_and_check(input logic [7:0] v, input string req);
      logic [7:0] got; bit ok;
      fork
         capture_tx(got, ok);
         bus_write(A_DATA, v);
      join
      chk(ok && got == v, req, got, v);
      repeat (bp) @(posedge clk);
   endtask

   task automatic recv_and_check(input logic [7:0] v, input string req);
      logic [7:0] s, d;
      drive_frame(v, 1'b1);
      bus_read(A_CTRL, s);
      chk(s == exp_status(1, 0, 0), req, s, exp_status(1, 0, 0));
      bus_read(A_DATA, d);
      chk(d == v, req, d, v);
      bus_read(A_CTRL, s);
      chk(s == exp_status(0, 0, 0), req, s, exp_status(0, 0, 0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      logic [7:0] s, d, a, b;
      bit ok1, ok2;
      int low;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: reset state
      chk(txd === 1'b1, "R8 txd", txd, 1);
      bus_read(A_CTRL, s);
      chk(s == 8'h00, "R8 status", s, 0);

      // R1: divisor 0 gives a 16 cycle start bit (data 0xFF)
      fork
         begin
            low = 0;
            @(negedge txd);
            @(posedge clk); #1;
            while (txd === 1'b0) begin low++; @(posedge clk); #1; end
         end
         bus_write(A_DATA, 8'hFF);
      join
      chk(low >= 15 && low <= 17, "R1 div0 bit", low, 16);
      repeat (12 * bp) @(posedge clk);

      // R1: divisor 2 gives 48 cycles, within one tick of phase
      set_div(2);
      fork
         begin
            low = 0;
            @(negedge txd);
            @(posedge clk); #1;
            while (txd === 1'b0) begin low++; @(posedge clk); #1; end
         end
         bus_write(A_DATA, 8'hFF);
      join
      chk(low >= 15 * 3 && low <= 16 * 3 + 1, "R1 div2 bit", low, 48);
      repeat (12 * bp) @(posedge clk);
      set_div(0);

      // R3: directed patterns, LSB first
      send_and_check(8'h01, "R3 lsb");
      send_and_check(8'h80, "R3 msb");
      send_and_check(8'h00, "R3 zero");

      // R4: double buffering, third write while full is discarded
      a = 8'h3C; b = 8'hA5;
      fork
         begin
            capture_tx(d, ok1);
            chk(ok1 && d == a, "R4 first", d, a);
            capture_tx(d, ok2);
            chk(ok2 && d == b, "R4 second", d, b);
         end
         begin
            bus_write(A_DATA, a);
            bus_write(A_DATA, b);
            bus_read(A_CTRL, s);
            chk(s == exp_status(0, 1, 0), "R4 full flag", s, exp_status(0, 1, 0));
            bus_write(A_DATA, 8'h77);
         end
      join
      low = 0;
      repeat (30 * bp) begin @(posedge clk); #1; if (txd !== 1'b1) low++; end
      chk(low == 0, "R4 dropped write", low, 0);
      bus_read(A_CTRL, s);
      chk(s == 8'h00, "R4 full clears", s, 0);

      // R5: receive directed
      recv_and_check(8'hC3, "R5 rx");

      // R6: overrun
      drive_frame(8'h11, 1'b1);
      drive_frame(8'h22, 1'b1);
      bus_read(A_CTRL, s);
      chk(s == exp_status(1, 0, 1), "R6 overrun set", s, exp_status(1, 0, 1));
      bus_read(A_DATA, d);
      chk(d == 8'h22, "R6 newest kept", d, 8'h22);
      bus_read(A_CTRL, s);
      chk(s == 8'h00, "R6 cleared", s, 0);

      // R7: short glitch and bad stop bit
      @(posedge clk); #1 rxd = 1'b0;
      repeat (3) @(posedge clk);
      #1 rxd = 1'b1;
      repeat (3 * bp) @(posedge clk);
      bus_read(A_CTRL, s);
      chk(s == 8'h00, "R7 glitch", s, 0);
      drive_frame(8'h5A, 1'b0);
      bus_read(A_CTRL, s);
      chk(s == 8'h00, "R7 bad stop", s, 0);
      recv_and_check(8'h96, "R7 recovers");

      // R2/R5/R3: random bytes at random divisors
      for (int i = 0; i < 8; i++) begin
         logic [7:0] v;
         set_div(int'($urandom_range(0, 2)));
         v = 8'($urandom);
         recv_and_check(v, "R2 R5 random rx");
         v = 8'($urandom);
         send_and_check(v, "R3 random tx");
      end

      summary();
   end
endmodule